// File: doc/BRIEF.md
# Codec Register Write Sequencer

This block brings an external audio codec out of reset by walking a fixed, built-in table of register writes. Each table entry is a 7-bit register index and a 9-bit value. The block sends each entry as one two-byte I2C write to the codec's 7-bit device address. The 16 bits are packed so that the register index fills the upper seven bits and the value fills the lower nine. Bit 8 of the value therefore lands in the least significant bit of the first data byte.

The block does not drive the I2C bus directly. It gives a byte-level master engine one command at a time: start condition, write byte or stop condition. It holds each command until the engine reports the command complete, together with an acknowledge or not-acknowledge. The codec cannot return a register in the format it was written, so the block keeps a shadow array of the last acknowledged value for every register index. Other logic reads this array through a combinational port. A not-acknowledge on any byte stops the walk, sends a stop condition and records which table entry failed.

Top module: `codec_init_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `error` and `i2c_cmd_valid` are low, and every shadow entry reads 0.
- R2: A one-cycle `start` pulse, given while idle, finished or failed, begins the walk at table entry 0. A `start` pulse during a walk has no effect on the command stream.
- R3: Each table entry is one transaction with exactly five commands, in this order: start (`i2c_cmd`=2'b00), a write (2'b01) of the address byte 0x34 (device address 0x1A shifted left with the write bit 0), two data-byte writes, and stop (2'b10).
- R4: The first data byte is the register index shifted left by one, ORed with value bit 8. The second data byte is value bits 7..0.
- R5: The table is walked in this order: (0x0F,0x000) reset first, then (0x19,0x0C0), (0x1A,0x1E0), (0x04,0x000), (0x07,0x002), (0x0A,0x0F0), (0x0B,0x1F0), (0x02,0x070), (0x03,0x170), (0x22,0x100), (0x25,0x100). In each left/right pair the left register comes first and the right value has bit 8 set.
- R6: While `i2c_cmd_valid` is high and `i2c_cmd_done` is low, the command and `i2c_wdata` stay unchanged.
- R7: After the stop of the last entry is completed, `done` rises on the next clock edge, `busy` falls, and `done` stays high until the next accepted `start`.
- R8: A not-acknowledge on any write byte is followed by a stop command and no further transactions. `error` then rises and `err_index` holds the failing table entry.
- R9: A shadow entry is written only when the second data byte of its transaction is acknowledged. `shadow_data` returns the last written value for `shadow_addr`, or 0 for a register never written.
- R10: `done` and `error` are never high together. An accepted `start` clears both, and `err_index` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Whole table written and acknowledged |
| error | output | 1 | Walk aborted on a not-acknowledge |
| err_index | output | 4 | Table entry that failed |
| i2c_cmd_valid | output | 1 | Command to the byte engine is pending |
| i2c_cmd | output | 2 | 00 start, 01 write byte, 10 stop |
| i2c_wdata | output | 8 | Byte to write with a write command |
| i2c_cmd_done | input | 1 | Engine finished the pending command (one cycle) |
| i2c_cmd_nack | input | 1 | With `i2c_cmd_done`: byte was not acknowledged |
| shadow_addr | input | 7 | Shadow array read index |
| shadow_data | output | 9 | Last acknowledged value for that index |

## Verification
Some rules are checked by assertions on every cycle. A pending command stays stable until it completes. Every transaction opens with a start. A not-acknowledge is followed directly by a stop. The shadow array is written only on an acknowledged byte. `done` never overlaps a pending command or `error`. Other behaviour only the bench scenarios can show: the exact byte content and order across the whole table, the table index recorded on a not-acknowledge at each byte position, shadow contents after partial and full runs, and a restart after a failure.

// File: rtl/codec_seq_pkg.sv
// Package: shared widths, command encoding, table entry type and the
// built-in write table for the codec register write sequencer.
// Assumes a 7-bit register index and 9-bit value packed into 16 bits.
package codec_seq_pkg;

    localparam int REG_W    = 7;
    localparam int VAL_W    = 9;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = REG_W + VAL_W;
    localparam int NUM_REGS = 1 << REG_W;
    localparam int TBL_LEN  = 11;
    localparam int IDX_W    = $clog2(TBL_LEN);

    typedef enum logic [1:0] {
        CMD_START = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_STOP  = 2'b10
    } i2c_cmd_e;

    typedef struct packed {
        logic [REG_W-1:0] reg_idx;
        logic [VAL_W-1:0] value;
    } wr_entry_t;

    // Return table entry i; the reset write must stay at index 0.
    function automatic wr_entry_t tbl_entry(input logic [IDX_W-1:0] i);
        wr_entry_t e;
        case (i)
            4'd0:    e = '{reg_idx: 7'h0F, value: 9'h000};
            4'd1:    e = '{reg_idx: 7'h19, value: 9'h0C0};
            4'd2:    e = '{reg_idx: 7'h1A, value: 9'h1E0};
            4'd3:    e = '{reg_idx: 7'h04, value: 9'h000};
            4'd4:    e = '{reg_idx: 7'h07, value: 9'h002};
            4'd5:    e = '{reg_idx: 7'h0A, value: 9'h0F0};
            4'd6:    e = '{reg_idx: 7'h0B, value: 9'h1F0};
            4'd7:    e = '{reg_idx: 7'h02, value: 9'h070};
            4'd8:    e = '{reg_idx: 7'h03, value: 9'h170};
            4'd9:    e = '{reg_idx: 7'h22, value: 9'h100};
            4'd10:   e = '{reg_idx: 7'h25, value: 9'h100};
            default: e = '{reg_idx: 7'h00, value: 9'h000};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/codec_seq_rom.sv
// Module: table lookup. Turns a table index into a register/value entry.
// Assumes the index stays below TBL_LEN while it is in use.
module codec_seq_rom
    import codec_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output wr_entry_t        entry
);

    // Combinational lookup into the fixed table.
    always_comb entry = tbl_entry(idx);

    // The walk pointer never runs past the table.
    p_idx_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(TBL_LEN));

endmodule

// File: rtl/codec_seq_pack.sv
// Module: byte packer. Splits an entry into the two data bytes sent on
// the bus: register index in word bits 15..9, value in bits 8..0.
// Assumes REG_W + VAL_W is twice the byte width.
module codec_seq_pack
    import codec_seq_pkg::*;
(
    input  wr_entry_t          entry,
    output logic [BYTE_W-1:0]  hi_byte,
    output logic [BYTE_W-1:0]  lo_byte
);

    logic [WORD_W-1:0] word;

    // Concatenate the fields and cut the word into bytes, high byte first.
    always_comb begin
        word    = {entry.reg_idx, entry.value};
        hi_byte = word[WORD_W-1 -: BYTE_W];
        lo_byte = word[BYTE_W-1:0];
    end

endmodule

// File: rtl/codec_seq_shadow.sv
// Module: shadow register array. Holds the last acknowledged value for
// every codec register index; read combinationally.
// Assumes at most one write per cycle.
module codec_seq_shadow
    import codec_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] waddr,
    input  logic [VAL_W-1:0] wdata,
    input  logic [REG_W-1:0] raddr,
    output logic [VAL_W-1:0] rdata
);

    logic [VAL_W-1:0] mem [NUM_REGS];

    // One storage word per register index, cleared on reset.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && waddr == REG_W'(g))
                mem[g] <= wdata;
        end
    end

    // Combinational read port.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/codec_seq_ctrl.sv
// Module: sequencing FSM. Walks the table, issues start / address /
// two data bytes / stop per entry, aborts on a not-acknowledge.
// Assumes the byte engine holds off i2c_cmd_done until it has finished
// the pending command and pulses it for one cycle.
module codec_seq_ctrl
    import codec_seq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_done,
    input  logic              cmd_nack,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    output logic [IDX_W-1:0]  idx,
    output logic              cmd_valid,
    output logic [1:0]        cmd,
    output logic [BYTE_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [IDX_W-1:0]  err_index,
    output logic              shadow_we
);

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(TBL_LEN - 1);
    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_ADDR, S_HI, S_LO, S_STOP, S_DONE, S_FAIL
    } st_e;

    st_e  state;
    logic abort;

    // State, table pointer, abort flag and failing index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            idx       <= '0;
            abort     <= 1'b0;
            err_index <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE, S_FAIL: begin
                    if (start) begin
                        state     <= S_START;
                        idx       <= '0;
                        abort     <= 1'b0;
                        err_index <= '0;
                    end
                end
                S_START: begin
                    if (cmd_done) state <= S_ADDR;
                end
                S_ADDR, S_HI, S_LO: begin
                    if (cmd_done) begin
                        if (cmd_nack) begin
                            abort     <= 1'b1;
                            err_index <= idx;
                            state     <= S_STOP;
                        end else begin
                            state <= (state == S_ADDR) ? S_HI :
                                     (state == S_HI)   ? S_LO : S_STOP;
                        end
                    end
                end
                S_STOP: begin
                    if (cmd_done) begin
                        if (abort)
                            state <= S_FAIL;
                        else if (idx == LAST_IDX)
                            state <= S_DONE;
                        else begin
                            idx   <= idx + 1'b1;
                            state <= S_START;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Command, byte and status outputs decoded from the state.
    always_comb begin
        cmd_valid = (state == S_START) || (state == S_ADDR) || (state == S_HI) ||
                    (state == S_LO) || (state == S_STOP);
        case (state)
            S_START: cmd = CMD_START;
            S_STOP:  cmd = CMD_STOP;
            default: cmd = CMD_WRITE;
        endcase
        case (state)
            S_ADDR:  wdata = ADDR_BYTE;
            S_HI:    wdata = hi_byte;
            S_LO:    wdata = lo_byte;
            default: wdata = '0;
        endcase
        busy      = cmd_valid;
        done      = (state == S_DONE);
        error     = (state == S_FAIL);
        shadow_we = (state == S_LO) && cmd_done && !cmd_nack;
    end

    // Pending command is held until the engine completes it.
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd) && $stable(wdata)));

    // A fresh command stream always opens with a start condition.
    p_open_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> (cmd == CMD_START));

    // A refused byte is followed directly by a stop condition.
    p_nack_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == CMD_WRITE && cmd_done && cmd_nack) |=>
        (cmd_valid && cmd == CMD_STOP));

    // Error only appears right after a completed stop.
    p_err_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(cmd_valid && cmd == CMD_STOP && cmd_done));

    // Start during a walk does not disturb it.
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !cmd_done) |=> busy);

    // Finished means quiet bus and no error.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_valid && !error));

    // Completion and failure are exclusive.
    p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

endmodule

// File: rtl/codec_init_seq.sv
// Module: top of the codec register write sequencer. Connects table,
// packer, FSM and shadow array; presents the byte command interface.
// Assumes a byte-level I2C master that acknowledges each command with
// a one-cycle i2c_cmd_done.
module codec_init_seq
    import codec_seq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [IDX_W-1:0]  err_index,
    output logic              i2c_cmd_valid,
    output logic [1:0]        i2c_cmd,
    output logic [BYTE_W-1:0] i2c_wdata,
    input  logic              i2c_cmd_done,
    input  logic              i2c_cmd_nack,
    input  logic [REG_W-1:0]  shadow_addr,
    output logic [VAL_W-1:0]  shadow_data
);

    logic [IDX_W-1:0]  idx;
    wr_entry_t         entry;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;
    logic              shadow_we;

    codec_seq_rom u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (idx),
        .entry (entry)
    );

    codec_seq_pack u_pack (
        .entry   (entry),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte)
    );

    codec_seq_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_done  (i2c_cmd_done),
        .cmd_nack  (i2c_cmd_nack),
        .hi_byte   (hi_byte),
        .lo_byte   (lo_byte),
        .idx       (idx),
        .cmd_valid (i2c_cmd_valid),
        .cmd       (i2c_cmd),
        .wdata     (i2c_wdata),
        .busy      (busy),
        .done      (done),
        .error     (error),
        .err_index (err_index),
        .shadow_we (shadow_we)
    );

    codec_seq_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (shadow_we),
        .waddr (entry.reg_idx),
        .wdata (entry.value),
        .raddr (shadow_addr),
        .rdata (shadow_data)
    );

    // Shadow is written only on an acknowledged write byte.
    p_shadow_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_we |-> (i2c_cmd_valid && i2c_cmd == CMD_WRITE &&
                       i2c_cmd_done && !i2c_cmd_nack));

endmodule

// File: tb/codec_init_seq_tb.sv
module codec_init_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, error;
    logic [3:0] err_index;
    logic       i2c_cmd_valid;
    logic [1:0] i2c_cmd;
    logic [7:0] i2c_wdata;
    logic       i2c_cmd_done = 1'b0;
    logic       i2c_cmd_nack = 1'b0;
    logic [6:0] shadow_addr = '0;
    logic [8:0] shadow_data;

    always #2.5 clk = ~clk;

    codec_init_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .error(error), .err_index(err_index), .i2c_cmd_valid(i2c_cmd_valid),
        .i2c_cmd(i2c_cmd), .i2c_wdata(i2c_wdata), .i2c_cmd_done(i2c_cmd_done),
        .i2c_cmd_nack(i2c_cmd_nack), .shadow_addr(shadow_addr),
        .shadow_data(shadow_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // Byte engine model state and command log.
    logic [1:0] lg_cmd  [128];
    logic [7:0] lg_data [128];
    int   lg_n = 0, starts = 0, bpos = 0, lat = 0;
    int   nack_entry = -1, nack_pos = 0;
    logic log_clr = 1'b0, stab_bad = 1'b0;
    logic [1:0] hold_cmd;
    logic [7:0] hold_data;

    // Expected-command buffer.
    logic [1:0] ex_cmd  [128];
    logic [7:0] ex_data [128];
    int   ex_n;

    // Scenario vectors: nack entry, nack byte position (1 addr, 2 first
    // data, 3 second data, 0 none), shadow index and expected value.
    localparam int NV = 5;
    localparam int V_E  [NV] = '{10, 0, 6, 10, 5};
    localparam int V_P  [NV] = '{0, 1, 3, 2, 1};
    localparam int V_SR [NV] = '{'h0B, 'h19, 'h0B, 'h25, 'h07};
    localparam int V_SV [NV] = '{'h1F0, 0, 0, 0, 'h002};

    function automatic logic [6:0] exp_reg(int e);
        case (e)
            0: return 7'h0F;  1: return 7'h19;  2: return 7'h1A;  3: return 7'h04;
            4: return 7'h07;  5: return 7'h0A;  6: return 7'h0B;  7: return 7'h02;
            8: return 7'h03;  9: return 7'h22;  default: return 7'h25;
        endcase
    endfunction

    function automatic logic [8:0] exp_val(int e);
        case (e)
            0: return 9'h000; 1: return 9'h0C0; 2: return 9'h1E0; 3: return 9'h000;
            4: return 9'h002; 5: return 9'h0F0; 6: return 9'h1F0; 7: return 9'h070;
            8: return 9'h170; 9: return 9'h100; default: return 9'h100;
        endcase
    endfunction

    // Byte engine model: two-cycle latency, one-cycle completion pulse.
    always @(negedge clk) begin
        if (!rst_n || log_clr) begin
            lg_n = 0; starts = 0; bpos = 0; lat = 0; stab_bad = 1'b0;
            i2c_cmd_done = 1'b0; i2c_cmd_nack = 1'b0;
        end else if (i2c_cmd_done) begin
            i2c_cmd_done = 1'b0; i2c_cmd_nack = 1'b0; lat = 0;
        end else if (i2c_cmd_valid) begin
            if (lat == 0) begin
                hold_cmd = i2c_cmd; hold_data = i2c_wdata;
            end else if (i2c_cmd != hold_cmd || i2c_wdata != hold_data) begin
                stab_bad = 1'b1;
            end
            if (lat < 2) lat++;
            else begin
                if (lg_n < 128) begin
                    lg_cmd[lg_n] = i2c_cmd; lg_data[lg_n] = i2c_wdata;
                end
                lg_n++;
                if (i2c_cmd == 2'b00) begin starts++; bpos = 0; end
                else if (i2c_cmd == 2'b01) bpos++;
                i2c_cmd_nack = (i2c_cmd == 2'b01) && (starts - 1 == nack_entry) &&
                               (bpos == nack_pos);
                i2c_cmd_done = 1'b1;
            end
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000 && !(done || error); i++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic void push(logic [1:0] c, logic [7:0] d);
        ex_cmd[ex_n] = c; ex_data[ex_n] = d; ex_n++;
    endfunction

    // Build the expected command stream from the requirements.
    function automatic void build_exp(int last_e, int npos);
        logic [15:0] w;
        ex_n = 0;
        for (int e = 0; e <= last_e; e++) begin
            w = {exp_reg(e), exp_val(e)};
            push(2'b00, 8'h00);
            push(2'b01, 8'h34);
            if (e == last_e && npos == 1) begin push(2'b10, 8'h00); break; end
            push(2'b01, w[15:8]);
            if (e == last_e && npos == 2) begin push(2'b10, 8'h00); break; end
            push(2'b01, w[7:0]);
            push(2'b10, 8'h00);
        end
    endfunction

    // Compare the logged stream with the expected one.
    task automatic check_log(input string tag, input int last_e, input int npos);
        int bad_at = -1;
        build_exp(last_e, npos);
        check({tag, " R3/R8 command count"}, lg_n, ex_n);
        for (int k = 0; k < ex_n && k < lg_n; k++) begin
            if (bad_at < 0 && (lg_cmd[k] !== ex_cmd[k] ||
                (ex_cmd[k] == 2'b01 && lg_data[k] !== ex_data[k])))
                bad_at = k;
        end
        if (bad_at < 0) check({tag, " R4/R5 command stream"}, 0, 0);
        else check({tag, " R4/R5 command stream"},
                   {22'd0, lg_cmd[bad_at], lg_data[bad_at]},
                   {22'd0, ex_cmd[bad_at], ex_data[bad_at]});
        check({tag, " R6 command stable while pending"}, stab_bad, 0);
    endtask

    task automatic read_shadow(input logic [6:0] a, output logic [8:0] v);
        @(negedge clk); shadow_addr = a; #1; v = shadow_data;
    endtask

    initial begin
        logic [8:0] sv;

        // R1: reset state.
        do_reset();
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
        check("R1 error after reset", error, 0);
        check("R1 cmd_valid after reset", i2c_cmd_valid, 0);
        read_shadow(7'h0B, sv);
        check("R1 shadow cleared", sv, 0);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            nack_entry = (V_P[v] != 0) ? V_E[v] : -1;
            nack_pos   = V_P[v];
            do_reset();
            pulse_start();
            wait_end();
            check_log($sformatf("vec%0d", v), V_E[v], V_P[v]);
            if (V_P[v] == 0) begin
                check("R7 done after final stop", done, 1);
                check("R10 error low on success", error, 0);
            end else begin
                check("R8 error after nack", error, 1);
                check("R8 failing index", err_index, V_E[v]);
                check("R10 done low on failure", done, 0);
            end
            check("R7 busy low at end", busy, 0);
            read_shadow(V_SR[v][6:0], sv);
            check("R9 shadow value", sv, V_SV[v]);
            read_shadow(7'h30, sv);
            check("R9 unwritten shadow reads 0", sv, 0);
        end

        // R5/R9: shadow after a full run, right value with bit 8 applied.
        nack_entry = -1; nack_pos = 0;
        do_reset();
        pulse_start();
        wait_end();
        read_shadow(7'h0A, sv);
        check("R5 left volume shadow", sv, 9'h0F0);
        read_shadow(7'h03, sv);
        check("R5 right volume shadow bit 8", sv, 9'h170);
        read_shadow(7'h0F, sv);
        check("R9 reset register shadow", sv, 9'h000);
        repeat (10) @(negedge clk);
        check("R7 done held", done, 1);

        // R2: start pulses during a walk have no effect.
        do_reset();
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        repeat (57) @(negedge clk);
        pulse_start();
        wait_end();
        check_log("R2 restart ignored", 10, 0);
        check("R2 done after ignored starts", done, 1);

        // R10: restart after a failure, without reset.
        nack_entry = 4; nack_pos = 2;
        do_reset();
        pulse_start();
        wait_end();
        check("R8 error before restart", error, 1);
        check("R8 index before restart", err_index, 4);
        nack_entry = -1; nack_pos = 0;
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        pulse_start();
        check("R10 error cleared by start", error, 0);
        check("R10 err_index cleared by start", err_index, 0);
        wait_end();
        check_log("R10 restart", 10, 0);
        check("R10 done after restart", done, 1);
        check("R10 error low after restart", error, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule